// File: doc/BRIEF.md
# Bridge Power State Controller

This block keeps the device power state of a two-port bus bridge. Software reaches it through a simple register write/read port. The bridge itself supports only two software-visible states, full power (D0) and the low-power state with supply still present (D3hot). A two-bit field in the power control/status register selects the state. Requests for the two intermediate states, D1 and D2, are dropped.

**Entering D3hot.** Moving from D0 to D3hot stops the secondary bus clock outputs and holds them low. This happens only when the clock-control strap input permits it.

**Leaving D3hot.** Moving from D3hot back to D0 restores the clocks first. A one-cycle internal chip reset follows, and it returns the block's registers to their reset values. The secondary bus reset output stays deasserted throughout that sequence.

**Losing power.** Loss of power (D3cold) is modelled by the primary reset input. It forces D0 with the clocks running.

Top module: `bridge_pwr_state`

## Requirements
- R1: While and after the primary reset (active-low `rstN`), the power field reads D0, every `secClkEn` bit is 1, `chipRstPulse` is 0 and the scratch register reads 0.
- R2: The power field sits at bits [1:0] of the control/status register (address `PMCSR_ADDR`) with 00 = D0, 01 = D1, 10 = D2, 11 = D3hot. A write requesting 01 or 10 while in D0 is ignored, and the field keeps reading 00.
- R3: Writing 11 while in D0 makes the field read 11 from the next cycle. If `clkCtlStrap` was 1 on the write edge, every `secClkEn` bit drops to 0 in that same cycle; otherwise they stay 1.
- R4: While in D3hot, a write requesting 01, 10 or 11 leaves the field at 11 and the clock enables unchanged.
- R5: Writing 00 while in D3hot makes the field read 00 and every `secClkEn` bit read 1 from the next cycle. In the cycle after that, `chipRstPulse` is 1, for exactly one cycle.
- R6: The internal reset clears the wake-enable bit (bit 8 of the control/status register) and the scratch register (address `SCRATCH_ADDR`). Register writes presented in the two cycles that follow the waking write are dropped.
- R7: `secRstN` is 0 only while `rstN` is 0, rises on the first clock after release, and stays 1 during the internal reset.
- R8: `secBusB2` and bit 22 of the control/status register are 1 exactly while the field reads D3hot.
- R9: Bit 23 of the control/status register reads the current value of `clkCtlStrap`.
- R10: Asserting `rstN` while in D3hot (power removal) returns the field to D0 with all clocks enabled and without an internal reset pulse.
- R11: The wake-enable bit and the scratch register can be written in both D0 and D3hot. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Primary reset, active low, asynchronous assert |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register read data (combinational on `addr`) |
| clkCtlStrap | input | 1 | Strap allowing secondary clocks to be stopped in D3hot |
| secClkEn | output | NUM_SEC_CLK | Per-output secondary clock enable; 0 holds that clock low |
| chipRstPulse | output | 1 | One-cycle internal chip reset on leaving D3hot |
| secRstN | output | 1 | Secondary bus reset output, active low |
| secBusB2 | output | 1 | Secondary bus is in the B2 bus power state |

## Verification
The hardest situation to reach is a register write arriving inside the short window between the waking write and the end of the internal reset. The write must land there, and the bench must then show that the write vanished rather than surviving the clear. The stimulus issues the D0 request and then pushes scratch writes on each of the two following cycles, while it watches the clock enables and the pulse cycle by cycle. A second hard case is power removal from D3hot with clocks stopped. The bench reaches it by dropping the primary reset asynchronously mid-cycle while the block is asleep with the strap set.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pwrState_e;

  typedef enum logic [1:0] {
    FS_ON,
    FS_SLEEP,
    FS_WAKE,
    FS_RST
  } pmFsm_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadState;
    pwrState_e newState;
    logic      clkOff;
    logic      clkOn;
    logic      softRst;
  } pmStrobe_t;

  localparam int PS_LSB    = 0;
  localparam int WAKE_BIT  = 8;
  localparam int B2_BIT    = 22;
  localparam int STRAP_BIT = 23;

endpackage

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrPmcsr,
  input  logic [1:0] reqState,
  input  logic      clkCtlStrap,
  output pmStrobe_t strobe,
  output logic      busy,
  output logic      inD3
);

  pmFsm_e fsmQ, fsmD;

  always_comb begin
    fsmD             = fsmQ;
    strobe           = '0;
    strobe.newState  = PS_D0;
    unique case (fsmQ)
      FS_ON: begin
        if (wrPmcsr && reqState == PS_D3HOT) begin
          strobe.loadState = 1'b1;
          strobe.newState  = PS_D3HOT;
          strobe.clkOff    = clkCtlStrap;
          fsmD             = FS_SLEEP;
        end
      end
      FS_SLEEP: begin
        if (wrPmcsr && reqState == PS_D0) begin
          strobe.loadState = 1'b1;
          strobe.newState  = PS_D0;
          strobe.clkOn     = 1'b1;
          fsmD             = FS_WAKE;
        end
      end
      FS_WAKE: fsmD = FS_RST;
      FS_RST: begin
        strobe.softRst = 1'b1;
        fsmD           = FS_ON;
      end
      default: fsmD = FS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsmQ <= FS_ON;
    else       fsmQ <= fsmD;
  end

  assign busy = (fsmQ == FS_WAKE) || (fsmQ == FS_RST);
  assign inD3 = (fsmQ == FS_SLEEP);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> !strobe.softRst); // R5
  AST_PULSE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |-> $past(fsmQ) == FS_WAKE); // R5

endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
  import bpm_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                ADDR_W       = 8,
  parameter int                NUM_SEC_CLK  = 5,
  parameter logic [ADDR_W-1:0] PMCSR_ADDR   = 'h44,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 'h48
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pmStrobe_t              strobe,
  input  logic                   wrAcc,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   clkCtlStrap,
  output logic [DATA_W-1:0]      rdData,
  output logic [NUM_SEC_CLK-1:0] secClkEn,
  output logic                   secBusB2
);

  pwrState_e         stateQ;
  logic              clkEnQ;
  logic              wakeEnQ;
  logic [DATA_W-1:0] scratchQ;

  logic hitPmcsr, hitScratch;
  assign hitPmcsr   = (addr == PMCSR_ADDR);
  assign hitScratch = (addr == SCRATCH_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_D0;
      clkEnQ <= 1'b1;
    end else if (strobe.softRst) begin
      stateQ <= PS_D0;
      clkEnQ <= 1'b1;
    end else begin
      if (strobe.loadState) stateQ <= strobe.newState;
      if (strobe.clkOff)      clkEnQ <= 1'b0;
      else if (strobe.clkOn)  clkEnQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEnQ  <= 1'b0;
      scratchQ <= '0;
    end else if (strobe.softRst) begin
      wakeEnQ  <= 1'b0;
      scratchQ <= '0;
    end else if (wrAcc) begin
      if (hitPmcsr)   wakeEnQ  <= wrData[WAKE_BIT];
      if (hitScratch) scratchQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (hitPmcsr) begin
      rdData[PS_LSB +: 2] = stateQ;
      rdData[WAKE_BIT]    = wakeEnQ;
      rdData[B2_BIT]      = (stateQ == PS_D3HOT);
      rdData[STRAP_BIT]   = clkCtlStrap;
    end else if (hitScratch) begin
      rdData = scratchQ;
    end
  end

  for (genvar g = 0; g < NUM_SEC_CLK; g++) begin : gClkEn
    assign secClkEn[g] = clkEnQ;
  end

  assign secBusB2 = (stateQ == PS_D3HOT);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == PS_D0 || stateQ == PS_D3HOT); // R2
  AST_GATE_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEnQ) |-> $past(clkCtlStrap)); // R3
  AST_CLK_LOW_ONLY_D3: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnQ |-> stateQ == PS_D3HOT); // R3
  AST_CLK_BEFORE_RST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |-> clkEnQ && stateQ == PS_D0); // R5

endmodule

// File: rtl/bridge_pwr_state.sv
module bridge_pwr_state
  import bpm_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                ADDR_W       = 8,
  parameter int                NUM_SEC_CLK  = 5,
  parameter logic [ADDR_W-1:0] PMCSR_ADDR   = 'h44,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 'h48
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   clkCtlStrap,
  output logic [NUM_SEC_CLK-1:0] secClkEn,
  output logic                   chipRstPulse,
  output logic                   secRstN,
  output logic                   secBusB2
);

  localparam int MIN_DATA_W = STRAP_BIT + 1;
  if (DATA_W < MIN_DATA_W) begin : gWidthCheck
    initial $error("DATA_W too small for status fields");
  end

  pmStrobe_t strobe;
  logic      busy;
  logic      inD3;
  logic      wrAcc;
  logic      wrPmcsr;

  assign wrAcc   = wrEn && !busy;
  assign wrPmcsr = wrAcc && (addr == PMCSR_ADDR);

  bpm_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrPmcsr     (wrPmcsr),
    .reqState    (wrData[1:0]),
    .clkCtlStrap (clkCtlStrap),
    .strobe      (strobe),
    .busy        (busy),
    .inD3        (inD3)
  );

  bpm_regs #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .NUM_SEC_CLK  (NUM_SEC_CLK),
    .PMCSR_ADDR   (PMCSR_ADDR),
    .SCRATCH_ADDR (SCRATCH_ADDR)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrAcc       (wrAcc),
    .addr        (addr),
    .wrData      (wrData),
    .clkCtlStrap (clkCtlStrap),
    .rdData      (rdData),
    .secClkEn    (secClkEn),
    .secBusB2    (secBusB2)
  );

  // Secondary reset follows only the primary reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secRstN <= 1'b0;
    else       secRstN <= 1'b1;
  end

  assign chipRstPulse = strobe.softRst;

  AST_SECRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    chipRstPulse |-> secRstN); // R7
  AST_B2_MATCHES_FSM: assert property (@(posedge clk) disable iff (!rstN)
    secBusB2 == inD3); // R8

endmodule

// File: tb/bridge_pwr_state_bench.sv
module bridge_pwr_state_bench;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NC = 5;
  localparam logic [AW-1:0] A_PM = 8'h44;
  localparam logic [AW-1:0] A_SC = 8'h48;
  localparam logic [AW-1:0] A_NONE = 8'h10;
  localparam logic [NC-1:0] ALL_ON = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = A_PM;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          clkCtlStrap = 1'b0;
  logic [NC-1:0] secClkEn;
  logic          chipRstPulse;
  logic          secRstN;
  logic          secBusB2;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  bridge_pwr_state #(
    .DATA_W(DW), .ADDR_W(AW), .NUM_SEC_CLK(NC),
    .PMCSR_ADDR(A_PM), .SCRATCH_ADDR(A_SC)
  ) u_bridge_pwr_state (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .clkCtlStrap(clkCtlStrap), .secClkEn(secClkEn),
    .chipRstPulse(chipRstPulse), .secRstN(secRstN), .secBusB2(secBusB2)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive a write at a falling edge; returns at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #1;
    chk("R7 secRstN low in reset", {31'b0, secRstN}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    @(negedge clk);
    doReset();
    rd(A_PM, v);
    chk("R1 field D0", v[1:0], 0);
    chk("R1 clocks on", {27'b0, secClkEn}, {27'b0, ALL_ON});
    chk("R1 no pulse", {31'b0, chipRstPulse}, 0);
    chk("R7 secRstN high after reset", {31'b0, secRstN}, 1);
    rd(A_SC, v);
    chk("R1 scratch zero", v, 0);
    rd(A_NONE, v);
    chk("R11 unmapped reads 0", v, 0);

    for (int s = 0; s < 2; s++) begin
      clkCtlStrap = s[0];
      rd(A_PM, v);
      chk("R9 strap bit", {31'b0, v[23]}, s);
      for (int r = 0; r < 4; r++) begin
        logic expD3;
        expD3 = (r == 3);
        wr(A_PM, r);
        rd(A_PM, v);
        chk(expD3 ? "R3 field D3hot" : "R2 request ignored", v[1:0], expD3 ? 3 : 0);
        chk("R3 clock gating", {27'b0, secClkEn}, (expD3 && s == 1) ? 0 : {27'b0, ALL_ON});
        chk("R8 B2 bit", {31'b0, v[22]}, expD3);
        chk("R8 B2 port", {31'b0, secBusB2}, expD3);
        if (expD3) begin
          // writes to other fields in D3hot
          wr(A_SC, 32'hA5A5_0000 | (s << 4));
          rd(A_SC, v);
          chk("R11 scratch in D3hot", v, 32'hA5A5_0000 | (s << 4));
          wr(A_PM, 32'h0000_0103);
          rd(A_PM, v);
          chk("R11 wake bit in D3hot", {31'b0, v[8]}, 1);
          for (int k = 1; k < 4; k++) begin
            wr(A_PM, k);
            rd(A_PM, v);
            chk("R4 stays D3hot", v[1:0], 3);
            chk("R4 clocks unchanged", {27'b0, secClkEn}, (s == 1) ? 0 : {27'b0, ALL_ON});
          end
          // wake: write D0
          wr(A_PM, 32'h0000_0100);
          rd(A_PM, v);
          chk("R5 field D0", v[1:0], 0);
          chk("R5 clocks back", {27'b0, secClkEn}, {27'b0, ALL_ON});
          chk("R5 no pulse yet", {31'b0, chipRstPulse}, 0);
          wr(A_SC, 32'h1111_2222); // dropped: busy window
          chk("R5 pulse high", {31'b0, chipRstPulse}, 1);
          chk("R7 secRstN during pulse", {31'b0, secRstN}, 1);
          wr(A_SC, 32'h3333_4444); // dropped: busy window
          chk("R5 pulse one cycle", {31'b0, chipRstPulse}, 0);
          rd(A_SC, v);
          chk("R6 scratch cleared", v, 0);
          rd(A_PM, v);
          chk("R6 wake bit cleared", {31'b0, v[8]}, 0);
          chk("R8 B2 clear", {31'b0, secBusB2}, 0);
          // writes accepted again
          wr(A_PM, 32'h0000_0100);
          rd(A_PM, v);
          chk("R11 wake bit in D0", {31'b0, v[8]}, 1);
          wr(A_PM, 0);
        end
      end
    end

    // Power removal from D3hot with clocks stopped
    clkCtlStrap = 1'b1;
    wr(A_PM, 3);
    rd(A_PM, v);
    chk("R3 D3hot before power loss", v[1:0], 3);
    #3; rstN = 1'b0; #1;
    rd(A_PM, v);
    chk("R10 field D0", v[1:0], 0);
    chk("R10 clocks on", {27'b0, secClkEn}, {27'b0, ALL_ON});
    chk("R7 secRstN low", {31'b0, secRstN}, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 no pulse", {31'b0, chipRstPulse}, 0);
    end
    chk("R10 clocks still on", {27'b0, secClkEn}, {27'b0, ALL_ON});

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule